// File: doc/BRIEF.md
# Auto-Masking Priority Interrupt Controller

This block gathers a fixed number of active-high, level-sensitive interrupt lines and presents one of them at a time to a single processor. Each line can also be raised by software through a per-line trigger bit. A line counts as a live request only when its hardware level or its trigger bit is high and its mask bit is clear. Among the live lines, the one with the lowest index wins. A single interrupt request output goes high whenever any live line exists.

Software claims an interrupt by reading the event register. The read returns a valid flag, a source-type field and the winning line's number. At the same clock edge the controller sets that line's mask bit, so the line is not reported again until software clears the mask. The mask and trigger vectors are each reached through two addresses: writing ones to one address sets bits, and writing ones to the other clears them. A read of either address returns the current vector word. The read and write ports are independent, so a write and an event read can occur in the same cycle.

Register address = {kind[2:0], word index}. The kinds are 0 = event, 1 = mask set, 2 = mask clear, 3 = trigger set and 4 = trigger clear. Word index w covers lines 32*w to 32*w+31, with line 32*w+b at data bit b.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, every trigger bit is 0, cpu_irq is low and an event read returns 0.
- R2: A line's request is hw_irq[i] OR trigger[i]. A line whose mask bit is 1 never wins and never raises cpu_irq.
- R3: When several lines are live, the event read reports the lowest-numbered one.
- R4: An event read returns bit 31 = 1 (valid), bits 17:16 = 0 (hardware source type) and bits 15:0 = the line number. rd_valid and rd_data appear at the clock edge after the edge that samples rd_en.
- R5: The edge that samples an event read with a winner sets that line's mask bit. Later reads do not report the line until it is unmasked.
- R6: An event read with no live line returns 0 and changes no mask bit.
- R7: Writing ones to the mask-set address sets those mask bits, and writing ones to the mask-clear address clears them. Zero bits leave the mask unchanged. A read of either address returns the mask word.
- R8: Writing ones to the trigger-set address sets those trigger bits, and writing ones to the trigger-clear address clears them. A read of either address returns the trigger word.
- R9: cpu_irq is a combinational function of hw_irq and of the registered mask and trigger bits. It is high exactly when at least one live line exists.
- R10: When an event read masks a line in the same cycle that a mask-clear write clears that line, the line ends up masked.
- R11: Hardware lines are not latched. When hw_irq[i] falls, line i stops requesting.
- R12: Lines at index 32 and above are reached through word index 1. Their event numbers are their full indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | N_LINES | Level-sensitive interrupt lines |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3+IDX | Read address {kind, word index} |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3+IDX | Write address {kind, word index} |
| wr_data | input | 32 | Write data, one bit per line |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |
| cpu_irq | output | 1 | Interrupt request toward the processor |

## Verification
Read results, including event claims, are due exactly one cycle after the edge that samples rd_en. A driver task therefore pushes each expected word into a queue at issue time, and a monitor pops one entry at each falling edge where rd_valid is high. Mask and trigger writes take effect at the next edge, and cpu_irq follows combinationally. The bench samples cpu_irq a short delay after the falling edge that ends a write or an hw_irq change, so every register and input on its path has settled. The auto-mask is checked on the next read, one cycle after the claim.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WORD_W = 32;
  localparam int KIND_W = 3;

  localparam logic [KIND_W-1:0] K_EVENT = 3'd0;
  localparam logic [KIND_W-1:0] K_MSET  = 3'd1;
  localparam logic [KIND_W-1:0] K_MCLR  = 3'd2;
  localparam logic [KIND_W-1:0] K_TSET  = 3'd3;
  localparam logic [KIND_W-1:0] K_TCLR  = 3'd4;

  localparam logic [1:0] SRC_HW = 2'd0;

  function automatic int word_count(int n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int idx_width(int n);
    return (word_count(n) > 1) ? $clog2(word_count(n)) : 1;
  endfunction

  function automatic int addr_width(int n);
    return KIND_W + idx_width(n);
  endfunction

  // valid flag at bit 31, source type at 17:16, line number at 15:0
  function automatic logic [WORD_W-1:0] event_word(logic v, logic [1:0] src,
                                                   logic [15:0] num);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[31]    = v;
    w[17:16] = src;
    w[15:0]  = num;
    return w;
  endfunction
endpackage

// File: rtl/irqc_vec_reg.sv
module irqc_vec_reg #(
  parameter int N         = 48,
  parameter bit RESET_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] force_vec,
  output logic [N-1:0] q
);
  logic [N-1:0] nxt;

  // per-bit update: a forced set beats a clear, then a set beats a clear
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign nxt[i] = force_vec[i] | set_vec[i] | (q[i] & ~clr_vec[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= {N{RESET_ONE}};
    else     q <= nxt;
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> (q == {N{RESET_ONE}}));

  assert_force_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (force_vec != '0) |=> ((q & $past(force_vec)) == $past(force_vec)));
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int N    = 48,
  localparam int ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req,
  output logic            valid,
  output logic [ID_W-1:0] id
);
  // scan from the top so the lowest set index is the last one written
  always_comb begin
    valid = 1'b0;
    id    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        id    = ID_W'(i);
      end
    end
  end

  assert_winner_live_R2: assert property (@(posedge clk) disable iff (rst)
    valid |-> req[id]);

  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((req & ((N'(1) << id) - N'(1))) == '0));
endmodule

// File: rtl/irqc_bus.sv
module irqc_bus
  import irqc_pkg::*;
#(
  parameter int N_LINES = 48,
  localparam int ID_W   = $clog2(N_LINES),
  localparam int IDX_W  = idx_width(N_LINES),
  localparam int ADDR_W = addr_width(N_LINES),
  localparam int WORDS  = word_count(N_LINES),
  localparam int PAD_W  = WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [N_LINES-1:0] mask_q,
  input  logic [N_LINES-1:0] trig_q,
  input  logic               win_valid,
  input  logic [ID_W-1:0]    win_id,
  output logic [N_LINES-1:0] mask_set,
  output logic [N_LINES-1:0] mask_clr,
  output logic [N_LINES-1:0] trig_set,
  output logic [N_LINES-1:0] trig_clr,
  output logic [N_LINES-1:0] ack_vec,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rd_valid
);
  logic [KIND_W-1:0] wr_kind, rd_kind;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [PAD_W-1:0]  spread, mask_pad, trig_pad;
  logic [WORD_W-1:0] rd_word;
  logic              claim;

  assign wr_kind  = wr_addr[ADDR_W-1 -: KIND_W];
  assign wr_idx   = wr_addr[IDX_W-1:0];
  assign rd_kind  = rd_addr[ADDR_W-1 -: KIND_W];
  assign rd_idx   = rd_addr[IDX_W-1:0];
  assign mask_pad = PAD_W'(mask_q);
  assign trig_pad = PAD_W'(trig_q);

  // place the written word onto its lane of the line vector
  always_comb begin
    spread = '0;
    if (int'(wr_idx) < WORDS) spread[wr_idx*WORD_W +: WORD_W] = wr_data;
  end

  always_comb begin
    mask_set = '0;
    mask_clr = '0;
    trig_set = '0;
    trig_clr = '0;
    if (wr_en) begin
      case (wr_kind)
        K_MSET:  mask_set = spread[N_LINES-1:0];
        K_MCLR:  mask_clr = spread[N_LINES-1:0];
        K_TSET:  trig_set = spread[N_LINES-1:0];
        K_TCLR:  trig_clr = spread[N_LINES-1:0];
        default: ;
      endcase
    end
  end

  assign claim = rd_en && (rd_kind == K_EVENT) && win_valid;

  always_comb begin
    ack_vec = '0;
    if (claim) ack_vec[win_id] = 1'b1;
  end

  always_comb begin
    rd_word = '0;
    case (rd_kind)
      K_EVENT: if (win_valid) rd_word = event_word(1'b1, SRC_HW, 16'(win_id));
      K_MSET, K_MCLR:
        if (int'(rd_idx) < WORDS) rd_word = mask_pad[rd_idx*WORD_W +: WORD_W];
      K_TSET, K_TCLR:
        if (int'(rd_idx) < WORDS) rd_word = trig_pad[rd_idx*WORD_W +: WORD_W];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
    end
  end

  assert_rvalid_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  assert_single_claim_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_vec));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int N_LINES = 48
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_LINES-1:0]            hw_irq,
  input  logic                          rd_en,
  input  logic [addr_width(N_LINES)-1:0] rd_addr,
  input  logic                          wr_en,
  input  logic [addr_width(N_LINES)-1:0] wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  output logic [WORD_W-1:0]             rd_data,
  output logic                          rd_valid,
  output logic                          cpu_irq
);
  localparam int ID_W = $clog2(N_LINES);

  logic [N_LINES-1:0] mask_q, trig_q, live;
  logic [N_LINES-1:0] mask_set, mask_clr, trig_set, trig_clr, ack_vec;
  logic               win_valid;
  logic [ID_W-1:0]    win_id;

  assign live    = (hw_irq | trig_q) & ~mask_q;
  assign cpu_irq = |live;

  irqc_vec_reg #(.N(N_LINES), .RESET_ONE(1'b1)) u_mask (
    .clk(clk), .rst(rst), .set_vec(mask_set), .clr_vec(mask_clr),
    .force_vec(ack_vec), .q(mask_q));

  irqc_vec_reg #(.N(N_LINES), .RESET_ONE(1'b0)) u_trig (
    .clk(clk), .rst(rst), .set_vec(trig_set), .clr_vec(trig_clr),
    .force_vec({N_LINES{1'b0}}), .q(trig_q));

  irqc_prio_enc #(.N(N_LINES)) u_enc (
    .clk(clk), .rst(rst), .req(live), .valid(win_valid), .id(win_id));

  irqc_bus #(.N_LINES(N_LINES)) u_bus (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mask_q(mask_q), .trig_q(trig_q), .win_valid(win_valid), .win_id(win_id),
    .mask_set(mask_set), .mask_clr(mask_clr), .trig_set(trig_set),
    .trig_clr(trig_clr), .ack_vec(ack_vec), .rd_data(rd_data),
    .rd_valid(rd_valid));

  assert_irq_matches_winner_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == win_valid);

  assert_winner_unmasked_R2: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !mask_q[win_id]);
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  import irqc_pkg::*;
  localparam int N     = 48;
  localparam int AW    = addr_width(N);
  localparam int IW    = AW - KIND_W;
  localparam int PAD   = word_count(N) * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  hw_irq = '0;
  logic          rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          rd_valid, cpu_irq;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.N_LINES(N)) u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .cpu_irq(cpu_irq));

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int n_cmp = 0, n_bad = 0;
  logic [N-1:0] m_mask = '1, m_trig = '0;

  function automatic logic [AW-1:0] mk_addr(logic [2:0] kind, int idx);
    return {kind, IW'(idx)};
  endfunction

  function automatic logic [N-1:0] lane(int idx, logic [31:0] d);
    logic [PAD-1:0] p;
    p = PAD'(d) << (idx * 32);
    return p[N-1:0];
  endfunction

  function automatic logic [31:0] model_event();
    logic [N-1:0] lv;
    lv = (hw_irq | m_trig) & ~m_mask;
    for (int i = 0; i < N; i++)
      if (lv[i]) return {1'b1, 13'b0, 2'b00, 16'(i)};
    return '0;
  endfunction

  function automatic logic [31:0] word_of(logic [N-1:0] v, int idx);
    logic [PAD-1:0] p;
    p = PAD'(v);
    return p[idx*32 +: 32];
  endfunction

  task automatic compare(logic [31:0] act, logic [31:0] exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_write(logic [2:0] kind, int idx, logic [31:0] d);
    case (kind)
      K_MSET: m_mask = m_mask | lane(idx, d);
      K_MCLR: m_mask = m_mask & ~lane(idx, d);
      K_TSET: m_trig = m_trig | lane(idx, d);
      K_TCLR: m_trig = m_trig & ~lane(idx, d);
      default: ;
    endcase
  endtask

  task automatic do_write(logic [2:0] kind, int idx, logic [31:0] d);
    wr_en = 1'b1; wr_addr = mk_addr(kind, idx); wr_data = d;
    model_write(kind, idx, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic claim_event(string tag);
    logic [31:0] e;
    e = model_event();
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = mk_addr(K_EVENT, 0);
    if (e[31]) m_mask[e[5:0]] = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // event read and mask-clear write issued in the same cycle
  task automatic claim_with_unmask(int line, string tag);
    logic [31:0] e;
    e = model_event();
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = mk_addr(K_EVENT, 0);
    wr_en = 1'b1; wr_addr = mk_addr(K_MCLR, line / 32);
    wr_data = 32'(1) << (line % 32);
    model_write(K_MCLR, line / 32, wr_data);
    if (e[31]) m_mask[e[5:0]] = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic read_word(logic [2:0] kind, int idx, string tag);
    logic [31:0] e;
    e = (kind == K_MSET || kind == K_MCLR) ? word_of(m_mask, idx) : word_of(m_trig, idx);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = mk_addr(kind, idx);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_irq(string tag);
    #1;
    compare(32'(cpu_irq), 32'(|((hw_irq | m_trig) & ~m_mask)), tag);
  endtask

  task automatic set_hw(int line, logic v);
    hw_irq[line] = v;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4: actual unexpected read %h expected none", rd_data);
      end else begin
        compare(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_irq("R1 irq after reset");
    compare(model_event(), 32'h0, "R1 model sanity");
    claim_event("R1 event after reset");
    read_word(K_MSET, 0, "R1 mask word0");
    read_word(K_MCLR, 1, "R1 mask word1");
    read_word(K_TSET, 0, "R1 trigger word0");
    // R2 masked hardware line stays silent
    set_hw(5, 1'b1);
    check_irq("R2 masked line quiet");
    claim_event("R2 masked line not reported");
    // R7 unmask via W1C, R9 irq rises
    do_write(K_MCLR, 0, 32'h0000_0220);
    check_irq("R9 irq with live line");
    read_word(K_MSET, 0, "R7 mask after clear");
    // R4 event format, R5 auto-mask
    claim_event("R4 event line 5");
    check_irq("R5 irq drops after claim");
    read_word(K_MCLR, 0, "R5 mask bit set by claim");
    claim_event("R5 line not reported again");
    set_hw(5, 1'b0);
    // R8 software trigger
    do_write(K_TSET, 0, 32'h0000_0200);
    check_irq("R8 trigger raises irq");
    read_word(K_TCLR, 0, "R8 trigger word");
    claim_event("R8 trigger event line 9");
    do_write(K_TCLR, 0, 32'h0000_0200);
    read_word(K_TSET, 0, "R8 trigger cleared");
    // R3 priority, R12 upper word
    do_write(K_MCLR, 0, 32'h0000_0088);
    do_write(K_MCLR, 1, 32'h0000_0100);
    set_hw(7, 1'b1);
    set_hw(40, 1'b1);
    do_write(K_TSET, 0, 32'h0000_0008);
    claim_event("R3 lowest line 3 first");
    claim_event("R3 then line 7");
    claim_event("R12 then line 40");
    claim_event("R6 none left");
    read_word(K_MSET, 1, "R12 mask word1");
    // R6 empty read changes no mask
    do_write(K_MCLR, 0, 32'h0010_0000);
    claim_event("R6 empty claim");
    read_word(K_MSET, 0, "R6 mask unchanged");
    // R11 level, no latching
    set_hw(20, 1'b1);
    check_irq("R11 irq with level high");
    set_hw(20, 1'b0);
    check_irq("R11 irq after level drop");
    claim_event("R11 no latched event");
    // R10 claim beats same-cycle unmask
    set_hw(12, 1'b1);
    do_write(K_MCLR, 0, 32'h0000_1000);
    claim_with_unmask(12, "R10 claim line 12");
    read_word(K_MSET, 0, "R10 line 12 stays masked");
    check_irq("R10 irq low");
    // R7 W1S of mask
    do_write(K_MSET, 0, 32'h0010_0000);
    read_word(K_MCLR, 0, "R7 mask after set");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R4: actual %0d reads pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule